// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Sequencer

This block is the host-facing register front end of an eight-line interrupt controller. A host reaches it through a one-bit address, an eight-bit write bus, an eight-bit read bus and separate read and write strobes. Writes to the even address carry three kinds of word, told apart by data bits 4 and 3: an initialization opener, a control word that sets read selection, polling and special masking, and a control word that ends interrupts or moves the rotating priority base. Writes to the odd address load the mask register in normal operation. During initialization they instead feed a short sequence of follow-up words. The path through that sequence depends on two flags taken from the opener.

The block holds the mode flags, the interrupt vector base and the rotation base, together with the request, in-service and mask registers. An external arbiter reports the line it would grant on a pending-valid/pending-line pair. A poll read returns that line and acknowledges it. A small finder inside the block picks the highest-priority in-service line, counting from the rotation base, for non-specific end-of-interrupt commands.

Top module: `pic_cmd_sequencer`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears the request, in-service and mask registers, the vector base, the rotation base and every mode flag, and sets init_phase to 0 (normal).
- R2: An even-address write with data bit 4 set clears the request, in-service and mask registers, the vector base, the rotation base, poll arming, read-select, special mask, auto-EOI, rotate-on-auto-EOI and fully-nested. It also latches single mode from bit 1 and the need-fourth-word flag from bit 0, and sets init_phase to 1. init_phase encodes 0 = normal, 1 = awaiting vector word, 2 = awaiting cascade word, 3 = awaiting mode word.
- R3: In phase 1, an odd-address write sets vector_base to the data with bits 2:0 cleared. The next phase is 3 if single mode and the fourth word are both set, 0 if single mode is set alone, and 2 if single mode is clear.
- R4: In phase 2, an odd-address write leaves the mask unchanged and moves to phase 3 if the fourth word is needed, otherwise to phase 0. In phase 3, data bit 4 sets fully_nested, bit 1 sets auto_eoi, and the phase returns to 0.
- R5: In phase 0, an odd-address write loads the mask register, and a non-poll read of the odd address returns it.
- R6: An even-address write with bit 4 clear and bit 3 set arms polling when bit 2 is 1. When bit 1 is 1 it loads read-select from bit 0 (1 = in-service, 0 = request). When bit 6 is 1 it loads special_mask from bit 5.
- R7: An even-address write with bits 4 and 3 clear decodes command = bits 7:5. Commands 0 and 4 set rot_on_aeoi to bit 7.
- R8: Commands 1 and 5 clear the in-service bit of highest priority. Priority runs from line rot_base upward, modulo 8. Command 5 also sets rot_base to that line + 1 (mod 8).
- R9: Command 3 clears in-service bit data[2:0]. Command 7 does the same and sets rot_base to data[2:0] + 1. Command 6 sets rot_base to data[2:0] + 1. Command 2 changes nothing.
- R10: Commands 1 and 5 with an empty in-service register change neither the in-service register nor rot_base.
- R11: While polling is armed, rdata is 0x80 OR pend_line if pend_valid is 1, and 0x00 otherwise. A read in that state disarms polling. When pend_valid is 1, the read clears that request bit. It also sets that in-service bit when auto_eoi is 0. When auto_eoi and rot_on_aeoi are both 1, it sets rot_base to the line + 1 instead.
- R12: With polling not armed, an even-address read returns the in-service register when read-select is 1 and the request register when it is 0.
- R13: Each bit set on req_in at a clock edge sets the matching request bit. That bit stays set until it is acknowledged or cleared by an opener word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 1 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per word |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| req_in | input | 8 | Request set pulses, one per line |
| pend_valid | input | 1 | Arbiter has a line to grant |
| pend_line | input | 3 | Line the arbiter would grant |
| init_phase | output | 2 | Initialization phase (encoding in R2) |
| single_mode | output | 1 | Single-controller mode flag |
| vector_base | output | 8 | Vector base, low three bits zero |
| fully_nested | output | 1 | Special fully nested mode flag |
| auto_eoi | output | 1 | Automatic end-of-interrupt flag |
| rot_on_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| special_mask | output | 1 | Special mask mode flag |
| rot_base | output | 3 | Line holding highest priority |
| irr_q | output | 8 | Request register |
| isr_q | output | 8 | In-service register |
| imr_q | output | 8 | Mask register |

## Verification
The assertions assume that the host never raises wr_en and rd_en in the same cycle. Without that, a poll acknowledge and a command word could target the same in-service bit or the rotation base together. They also assume that pend_line stays within 0 to 7 and that pend_valid is only meaningful during a read. The bench drives each host access as a single-cycle strobe of one kind only. It raises pend_valid only around its own poll reads and pulses req_in only on cycles with no read or write. The sweeps cover every opener flag combination over a range of vector bases, every mask value, and non-specific end-of-interrupt over all rotation bases and a spread of in-service patterns.

// File: rtl/picseq_pkg.sv
// Shared constants and encodings for the interrupt controller sequencer.
// Assumes eight lines and an eight-bit host bus.
package picseq_pkg;
    localparam int LINES  = 8;
    localparam int DATA_W = 8;

    // Initialization phase; the values are visible on a port.
    typedef enum logic [1:0] {
        PH_NORMAL = 2'd0,
        PH_VECTOR = 2'd1,
        PH_CASC   = 2'd2,
        PH_MODE   = 2'd3
    } phase_e;

    // Command field of the end-of-interrupt/rotation word.
    typedef enum logic [2:0] {
        CMD_RAEOI_OFF = 3'd0,
        CMD_EOI_TOP   = 3'd1,
        CMD_IDLE      = 3'd2,
        CMD_EOI_LINE  = 3'd3,
        CMD_RAEOI_ON  = 3'd4,
        CMD_EOI_TOP_R = 3'd5,
        CMD_SET_BASE  = 3'd6,
        CMD_EOI_LINE_R= 3'd7
    } cmd_e;
endpackage

// File: rtl/picseq_prio_find.sv
// Finds the highest-priority set bit of a line vector, where priority
// starts at line 'base' and wraps upward.
// Assumes LINES is a power of two, so index arithmetic wraps naturally.
module picseq_prio_find #(
    parameter int LINES = picseq_pkg::LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] bits_in,
    input  logic [IDX_W-1:0] base,
    output logic             found,
    output logic [IDX_W-1:0] line
);
    logic [IDX_W-1:0] cand [LINES];

    // Candidate line for each priority rank.
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_rank
            assign cand[g] = base + IDX_W'(g);
        end
    endgenerate

    // Scan from lowest to highest rank so the highest set rank wins.
    always_comb begin
        found = 1'b0;
        line  = '0;
        for (int k = LINES - 1; k >= 0; k--) begin
            if (bits_in[cand[k]]) begin
                found = 1'b1;
                line  = cand[k];
            end
        end
    end

    // R8: a reported line is always one that is set.
    assert_found_is_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> bits_in[line]);
    // R10: nothing is reported for an empty vector.
    assert_empty_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bits_in == '0) |-> !found);
endmodule

// File: rtl/picseq_init_seq.sv
// Initialization word sequencer: tracks the phase, latches the opener
// flags, the vector base and the mode word, and says when an odd-address
// write is a mask load.
// Assumes icw1_wr and port1_wr are never high together (decoded from addr).
module picseq_init_seq #(
    parameter int LINES  = picseq_pkg::LINES,
    parameter int DATA_W = picseq_pkg::DATA_W,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               icw1_wr,
    input  logic               port1_wr,
    input  logic [DATA_W-1:0]  wdata,
    output picseq_pkg::phase_e phase,
    output logic               single_mode,
    output logic [DATA_W-1:0]  vector_base,
    output logic               fully_nested,
    output logic               auto_eoi,
    output logic               mask_load
);
    import picseq_pkg::*;

    localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << IDX_W) - 1);

    logic need_mode;

    // Phase register and the values latched along the init sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_NORMAL;
            need_mode    <= 1'b0;
            single_mode  <= 1'b0;
            vector_base  <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (icw1_wr) begin
            phase        <= PH_VECTOR;
            need_mode    <= wdata[0];
            single_mode  <= wdata[1];
            vector_base  <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (port1_wr) begin
            case (phase)
                PH_VECTOR: begin
                    vector_base <= wdata & ~LOW_MASK;
                    if (single_mode) phase <= need_mode ? PH_MODE : PH_NORMAL;
                    else             phase <= PH_CASC;
                end
                PH_CASC:  phase <= need_mode ? PH_MODE : PH_NORMAL;
                PH_MODE: begin
                    fully_nested <= wdata[4];
                    auto_eoi     <= wdata[1];
                    phase        <= PH_NORMAL;
                end
                default: ;
            endcase
        end
    end

    // Mask loads happen only outside the init sequence.
    assign mask_load = port1_wr && (phase == PH_NORMAL);

    // R1: reset returns the sequencer to normal with flags cleared.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (phase == PH_NORMAL) && !auto_eoi && !fully_nested && (vector_base == '0));
    // R2: an opener always leads to the vector phase.
    assert_opener_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        icw1_wr |=> (phase == PH_VECTOR));
    // R3: without single mode the vector word leads to the cascade phase.
    assert_cascade_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (port1_wr && phase == PH_VECTOR && !single_mode) |=> (phase == PH_CASC));
    // R4: the mode word always ends the sequence.
    assert_mode_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port1_wr && phase == PH_MODE) |=> (phase == PH_NORMAL));
endmodule

// File: rtl/picseq_ocw_unit.sv
// Operation command unit: executes end-of-interrupt, rotation and
// read/poll/special-mask control words, holds the rotation base and the
// control flags, and produces in-service clear requests.
// Assumes a poll read and a command write never fall in the same cycle.
module picseq_ocw_unit #(
    parameter int LINES  = picseq_pkg::LINES,
    parameter int DATA_W = picseq_pkg::DATA_W,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              icw1_wr,
    input  logic              ocw2_wr,
    input  logic              ocw3_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINES-1:0]  isr,
    input  logic              top_found,
    input  logic [IDX_W-1:0]  top_line,
    input  logic              poll_read,
    input  logic              poll_hit,
    input  logic [IDX_W-1:0]  poll_line,
    input  logic              auto_eoi,
    output logic [IDX_W-1:0]  rot_base,
    output logic              rot_on_aeoi,
    output logic              poll_armed,
    output logic              read_isr,
    output logic              special_mask,
    output logic [LINES-1:0]  isr_clr
);
    import picseq_pkg::*;

    cmd_e             cmd;
    logic [IDX_W-1:0] sel_line;

    assign cmd      = cmd_e'(wdata[DATA_W-1 -: 3]);
    assign sel_line = wdata[IDX_W-1:0];

    // Which in-service bit a command word clears.
    always_comb begin
        isr_clr = '0;
        if (ocw2_wr) begin
            case (cmd)
                CMD_EOI_TOP, CMD_EOI_TOP_R:
                    if (top_found) isr_clr[top_line] = 1'b1;
                CMD_EOI_LINE, CMD_EOI_LINE_R:
                    isr_clr[sel_line] = 1'b1;
                default: ;
            endcase
        end
    end

    // Rotation base, control flags and poll arming.
    always_ff @(posedge clk) begin
        if (!rst_n || icw1_wr) begin
            rot_base     <= '0;
            rot_on_aeoi  <= 1'b0;
            poll_armed   <= 1'b0;
            read_isr     <= 1'b0;
            special_mask <= 1'b0;
        end else begin
            if (ocw2_wr) begin
                case (cmd)
                    CMD_RAEOI_OFF, CMD_RAEOI_ON: rot_on_aeoi <= wdata[DATA_W-1];
                    CMD_EOI_TOP_R: if (top_found) rot_base <= top_line + 1'b1;
                    CMD_SET_BASE, CMD_EOI_LINE_R: rot_base <= sel_line + 1'b1;
                    default: ;
                endcase
            end
            if (ocw3_wr) begin
                if (wdata[2]) poll_armed   <= 1'b1;
                if (wdata[1]) read_isr     <= wdata[0];
                if (wdata[6]) special_mask <= wdata[5];
            end
            if (poll_read) begin
                poll_armed <= 1'b0;
                if (poll_hit && auto_eoi && rot_on_aeoi) rot_base <= poll_line + 1'b1;
            end
        end
    end

    // R9: the set-base command puts the chosen line + 1 at the top.
    assert_set_base_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ocw2_wr && wdata[DATA_W-1 -: 3] == 3'd6 && !poll_read)
        |=> (rot_base == $past(wdata[IDX_W-1:0]) + 1'b1));
    // R10: a rotating non-specific EOI with nothing in service keeps the base.
    assert_empty_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ocw2_wr && wdata[DATA_W-1 -: 3] == 3'd5 && isr == '0 && !poll_read)
        |=> $stable(rot_base));
    // R11: any read while armed disarms polling.
    assert_poll_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_read && !ocw3_wr) |=> !poll_armed);
endmodule

// File: rtl/picseq_line_regs.sv
// Request, in-service and mask registers for the eight lines.
// Assumes an acknowledge and an in-service clear never coincide.
module picseq_line_regs #(
    parameter int LINES  = picseq_pkg::LINES,
    parameter int DATA_W = picseq_pkg::DATA_W,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              mask_load,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LINES-1:0]  req_in,
    input  logic [LINES-1:0]  isr_clr,
    input  logic              ack_valid,
    input  logic [IDX_W-1:0]  ack_line,
    input  logic              ack_to_isr,
    output logic [LINES-1:0]  irr,
    output logic [LINES-1:0]  isr,
    output logic [LINES-1:0]  imr
);
    logic [LINES-1:0] ack_mask;

    // One-hot view of the acknowledged line.
    always_comb begin
        ack_mask = '0;
        if (ack_valid) ack_mask[ack_line] = 1'b1;
    end

    // Register updates: clear-all wins, then set and clear terms.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) begin
            irr <= '0;
            isr <= '0;
            imr <= '0;
        end else begin
            irr <= (irr & ~ack_mask) | req_in;
            isr <= (isr & ~isr_clr) | (ack_to_isr ? ack_mask : '0);
            if (mask_load) imr <= wdata[LINES-1:0];
        end
    end

    // R13: every request pulse is held in the request register.
    assert_req_latched_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in != '0 && !clear_all) |=> ((irr & $past(req_in)) == $past(req_in)));
    // R9: a requested in-service clear takes effect on the next cycle.
    assert_isr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_clr != '0 && !clear_all && !ack_valid) |=> ((isr & $past(isr_clr)) == '0));
    // R5: a mask load is visible on the next cycle.
    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_load && !clear_all) |=> (imr == $past(wdata[LINES-1:0])));
    // R11: an acknowledge into service sets exactly that line.
    assert_ack_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_to_isr && !clear_all) |=> isr[$past(ack_line)]);
endmodule

// File: rtl/pic_cmd_sequencer.sv
// Top of the command and initialization sequencer: decodes host writes on
// the shared even address, routes them to the init sequencer and the
// command unit, and muxes the read data including poll results.
// Assumes wr_en and rd_en are never high in the same cycle.
module pic_cmd_sequencer #(
    parameter int LINES  = picseq_pkg::LINES,
    parameter int DATA_W = picseq_pkg::DATA_W,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [LINES-1:0]  req_in,
    input  logic              pend_valid,
    input  logic [IDX_W-1:0]  pend_line,
    output logic [1:0]        init_phase,
    output logic              single_mode,
    output logic [DATA_W-1:0] vector_base,
    output logic              fully_nested,
    output logic              auto_eoi,
    output logic              rot_on_aeoi,
    output logic              special_mask,
    output logic [IDX_W-1:0]  rot_base,
    output logic [LINES-1:0]  irr_q,
    output logic [LINES-1:0]  isr_q,
    output logic [LINES-1:0]  imr_q
);
    import picseq_pkg::*;

    logic             wr_even, icw1_wr, ocw2_wr, ocw3_wr, port1_wr;
    logic             mask_load, poll_armed, read_isr, poll_read, ack_valid;
    logic             top_found;
    logic [IDX_W-1:0] top_line;
    logic [LINES-1:0] isr_clr;
    phase_e           phase;

    // Split even-address writes by data bits 4 and 3.
    assign wr_even  = wr_en && !addr;
    assign icw1_wr  = wr_even && wdata[4];
    assign ocw3_wr  = wr_even && !wdata[4] && wdata[3];
    assign ocw2_wr  = wr_even && !wdata[4] && !wdata[3];
    assign port1_wr = wr_en && addr;

    assign poll_read  = rd_en && poll_armed;
    assign ack_valid  = poll_read && pend_valid;
    assign init_phase = phase;

    picseq_init_seq #(.LINES(LINES), .DATA_W(DATA_W)) init_i (
        .clk(clk), .rst_n(rst_n), .icw1_wr(icw1_wr), .port1_wr(port1_wr),
        .wdata(wdata), .phase(phase), .single_mode(single_mode),
        .vector_base(vector_base), .fully_nested(fully_nested),
        .auto_eoi(auto_eoi), .mask_load(mask_load)
    );

    picseq_prio_find #(.LINES(LINES)) find_i (
        .clk(clk), .rst_n(rst_n), .bits_in(isr_q), .base(rot_base),
        .found(top_found), .line(top_line)
    );

    picseq_ocw_unit #(.LINES(LINES), .DATA_W(DATA_W)) ocw_i (
        .clk(clk), .rst_n(rst_n), .icw1_wr(icw1_wr), .ocw2_wr(ocw2_wr),
        .ocw3_wr(ocw3_wr), .wdata(wdata), .isr(isr_q), .top_found(top_found),
        .top_line(top_line), .poll_read(poll_read), .poll_hit(pend_valid),
        .poll_line(pend_line), .auto_eoi(auto_eoi), .rot_base(rot_base),
        .rot_on_aeoi(rot_on_aeoi), .poll_armed(poll_armed),
        .read_isr(read_isr), .special_mask(special_mask), .isr_clr(isr_clr)
    );

    picseq_line_regs #(.LINES(LINES), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .clear_all(icw1_wr), .mask_load(mask_load),
        .wdata(wdata), .req_in(req_in), .isr_clr(isr_clr),
        .ack_valid(ack_valid), .ack_line(pend_line), .ack_to_isr(!auto_eoi),
        .irr(irr_q), .isr(isr_q), .imr(imr_q)
    );

    // Read data: poll result while armed, else the addressed register.
    always_comb begin
        if (poll_armed) begin
            rdata = pend_valid ? {1'b1, {(DATA_W-1-IDX_W){1'b0}}, pend_line} : '0;
        end else if (addr) begin
            rdata = DATA_W'(imr_q);
        end else begin
            rdata = DATA_W'(read_isr ? isr_q : irr_q);
        end
    end

    // R11: an armed read with nothing pending returns zero.
    assert_poll_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_read && !pend_valid) |-> (rdata == '0));
    // R11: an acknowledge removes the request it granted.
    assert_ack_drops_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && req_in == '0) |=> !irr_q[$past(pend_line)]);
endmodule

// File: tb/pic_cmd_sequencer_tb_top.sv
module pic_cmd_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] req_in = 8'h00;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_line = 3'd0;
    logic [1:0] init_phase;
    logic       single_mode, fully_nested, auto_eoi, rot_on_aeoi, special_mask;
    logic [7:0] vector_base, irr_q, isr_q, imr_q;
    logic [2:0] rot_base;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cmd_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .req_in(req_in), .pend_valid(pend_valid),
        .pend_line(pend_line), .init_phase(init_phase), .single_mode(single_mode),
        .vector_base(vector_base), .fully_nested(fully_nested), .auto_eoi(auto_eoi),
        .rot_on_aeoi(rot_on_aeoi), .special_mask(special_mask), .rot_base(rot_base),
        .irr_q(irr_q), .isr_q(isr_q), .imr_q(imr_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Bring the block to normal with all defaults (cascade, no mode word).
    task automatic init_plain();
        do_write(1'b0, 8'h10);
        do_write(1'b1, 8'h00);
        do_write(1'b1, 8'h00);
    endtask

    // Put one line in service through a poll acknowledge.
    task automatic poll_ack(input logic [2:0] line, output logic [7:0] v);
        do_write(1'b0, 8'h0C);
        pend_valid = 1'b1; pend_line = line;
        do_read(1'b0, v);
        pend_valid = 1'b0;
    endtask

    function automatic logic [2:0] top_of(input logic [7:0] bits, input logic [2:0] base);
        for (int i = 7; i >= 0; i--) begin
            logic [2:0] l = base + 3'(i);
            if (bits[l]) top_of = l;
        end
        if (bits == 8'h00) top_of = 3'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, exp_isr;
        logic [2:0] exp_phase, ln;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 phase", init_phase, 0);
        chk("R1 flags", {single_mode, fully_nested, auto_eoi, rot_on_aeoi, special_mask}, 0);
        chk("R1 regs", {vector_base, irr_q, isr_q, imr_q, 5'd0, rot_base}, 0);
        do_read(1'b1, v); chk("R1 mask read", v, 0);

        // R5: every mask value loads and reads back
        for (int m = 0; m < 256; m++) begin
            do_write(1'b1, 8'(m));
            do_read(1'b1, v);
            chk("R5 mask", v, m);
        end

        // R2: opener clears the mask and enters phase 1
        do_write(1'b1, 8'hA5);
        do_write(1'b0, 8'h10);
        chk("R2 phase", init_phase, 1);
        chk("R2 mask cleared", imr_q, 0);

        // R3/R4: every opener flag pair over a range of vector bases
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 8; b++) begin
                logic [7:0] base_w = 8'(b * 37 + 3);
                logic sm = c[1], n4 = c[0];
                do_write(1'b1, 8'h5A);
                do_write(1'b0, {6'b000100, sm, n4});
                chk("R2 opener phase", init_phase, 1);
                chk("R2 single latched", single_mode, sm);
                do_write(1'b1, base_w);
                chk("R3 vector base", vector_base, base_w & 8'hF8);
                exp_phase = sm ? (n4 ? 3'd3 : 3'd0) : 3'd2;
                chk("R3 next phase", init_phase, exp_phase);
                if (exp_phase == 2) begin
                    do_write(1'b1, 8'hFF);
                    chk("R4 cascade word no mask", imr_q, 0);
                    chk("R4 after cascade", init_phase, n4 ? 3 : 0);
                end
                if (n4) begin
                    do_write(1'b1, 8'(b * 2));
                    chk("R4 mode flags", {fully_nested, auto_eoi}, {b[3] ? 1'b0 : 1'(((b*2) >> 4) & 1), 1'(((b*2) >> 1) & 1)});
                    chk("R4 back to normal", init_phase, 0);
                end
            end
        end

        // R6: control word flags
        init_plain();
        do_write(1'b0, 8'h68); chk("R6 special mask set", special_mask, 1);
        do_write(1'b0, 8'h28); chk("R6 special mask kept", special_mask, 1);
        do_write(1'b0, 8'h48); chk("R6 special mask clear", special_mask, 0);

        // R13/R12: requests latch and read through the select
        @(negedge clk); req_in = 8'h91;
        @(negedge clk); req_in = 8'h00;
        chk("R13 irr latched", irr_q, 8'h91);
        do_write(1'b0, 8'h0A);
        do_read(1'b0, v); chk("R12 read irr", v, 8'h91);
        do_write(1'b1, 8'h3C);
        do_read(1'b1, v); chk("R5 mask port", v, 8'h3C);

        // R11: poll acknowledge of line 0
        poll_ack(3'd0, v);
        chk("R11 poll value", v, 8'h80);
        chk("R11 irr after ack", irr_q, 8'h90);
        chk("R11 isr after ack", isr_q, 8'h01);
        do_read(1'b0, v); chk("R11 disarmed", v, 8'h90);
        do_write(1'b0, 8'h0B);
        do_read(1'b0, v); chk("R12 read isr", v, 8'h01);
        do_write(1'b0, 8'h0C);
        do_read(1'b0, v); chk("R11 nothing pending", v, 8'h00);
        chk("R11 empty poll no change", isr_q, 8'h01);

        // R9: specific commands and the idle command
        init_plain();
        poll_ack(3'd2, v); poll_ack(3'd5, v);
        chk("R11 poll value line5", v, 8'h85);
        do_write(1'b0, 8'h63); chk("R9 clear unset line", isr_q, 8'h24);
        do_write(1'b0, 8'h62); chk("R9 clear line 2", isr_q, 8'h20);
        do_write(1'b0, 8'hE5);
        chk("R9 rotating clear", isr_q, 8'h00);
        chk("R9 rotating base", rot_base, 6);
        poll_ack(3'd1, v);
        do_write(1'b0, 8'h40);
        chk("R9 idle isr", isr_q, 8'h02);
        chk("R9 idle base", rot_base, 6);
        do_write(1'b0, 8'hC7); chk("R9 set base wraps", rot_base, 0);

        // R7: rotate-on-auto-EOI on and off
        do_write(1'b0, 8'h80); chk("R7 set", rot_on_aeoi, 1);
        do_write(1'b0, 8'h00); chk("R7 clear", rot_on_aeoi, 0);

        // R11: auto-EOI acknowledge rotates instead of setting service
        do_write(1'b0, 8'h13);
        do_write(1'b1, 8'h40);
        chk("R3 single to mode word", init_phase, 3);
        do_write(1'b1, 8'h02);
        chk("R4 auto eoi", auto_eoi, 1);
        do_write(1'b0, 8'h80);
        poll_ack(3'd3, v);
        chk("R11 aeoi value", v, 8'h83);
        chk("R11 aeoi no service", isr_q, 8'h00);
        chk("R11 aeoi rotates", rot_base, 4);

        // R8/R10: non-specific EOI over all bases and many service patterns
        for (int base = 0; base < 8; base++) begin
            for (int p = 0; p < 256; p += 5) begin
                logic rot = p[0];
                init_plain();
                if (base != 0) do_write(1'b0, {5'b11000, 3'(base - 1)});
                for (int k = 0; k < 8; k++)
                    if (p[k]) poll_ack(3'(k), v);
                do_write(1'b0, rot ? 8'hA0 : 8'h20);
                ln = top_of(8'(p), 3'(base));
                exp_isr = 8'(p);
                if (p != 0) exp_isr[ln] = 1'b0;
                chk(p == 0 ? "R10 empty eoi isr" : "R8 eoi isr", isr_q, exp_isr);
                chk(p == 0 ? "R10 empty eoi base" : "R8 eoi base", rot_base,
                    (rot && p != 0) ? 3'(ln + 1) : 3'(base));
            end
        end

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset again", {init_phase, auto_eoi, rot_base, isr_q, imr_q}, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule